// File: doc/BRIEF.md
# Segmented Local/Global Memory Bridge

The bridge joins one processing node to two memory paths. The first is the node's own single-port memory bank. The second is a shared system bus that every node in the system can reach. All addresses are 32 bits wide, and each bank owns one slice of that space. The upper 32-m bits of an address give the slice number (the segment). The low m bits give the word offset inside the bank.

The bridge handles traffic in both directions:

- **Local requests.** Each request from the node is routed by its segment.
  - A request to the node's own segment goes to the bank. Only the offset is passed on.
  - Any other request goes out on the bus with its full address. The node then waits for the reply.
- **Bus requests.** The bridge watches requests on the bus. It serves those aimed at its own segment from the same bank and drives the reply back onto the bus.
- **Idle outputs.** Every bus-facing output is zero while it carries nothing. The outputs of all bridges can therefore be ORed onto one shared bus.

An external arbiter keeps the two users of the bank apart in time.

The local side uses a three-state machine:

| State | What it does | Leaves when |
|---|---|---|
| LIDLE | Accepts a request | The request is for the own segment: moves to LBANK, and the bank is accessed in the acceptance cycle. The request is for another segment: moves to LREMOTE. |
| LBANK | Returns the bank data with a one-cycle done pulse | Always returns to LIDLE |
| LREMOTE | Drives the request onto the bus | A bus reply arrives: returns to LIDLE |

The target side uses a two-state machine:

| State | What it does | Leaves when |
|---|---|---|
| TIDLE | Watches the bus | A request hits this segment: the bank is accessed and the machine moves to TREPLY |
| TREPLY | Drives a one-cycle reply | Always returns to TIDLE |

A bank multiplexer merges the two machines onto the single bank port.

Top module: `seg_mem_bridge`

## Requirements
- R1: While reset is asserted and the inputs are idle, `lcl_done`, `bank_en`, `bo_valid` and `bo_rsp_valid` are all 0.
- R2: A local read accepted in LIDLE whose segment (address bits 31:m) equals NODE_ID behaves as follows:
  - In the acceptance cycle, `bank_en`=1 and `bank_we`=0, and `bank_addr` carries address bits m-1:0.
  - In the next cycle, `lcl_done` pulses with `lcl_rdata` equal to the bank word.
  - The request therefore completes in two cycles.
- R3: A local write to the own segment behaves as follows:
  - In the acceptance cycle, `bank_en`=1 and `bank_we`=1, with the offset on `bank_addr` and the data on `bank_wdata`.
  - `lcl_done` pulses in the next cycle.
  - `bo_valid` stays 0 throughout.
- R4: For a local request whose segment differs from NODE_ID:
  - From the cycle after acceptance, `bo_valid`=1 and the full 32-bit address, the write flag and the write data appear on the bus.
  - All of them stay stable until `bi_rsp_valid` is seen.
- R5: In the cycle `bi_rsp_valid` is 1 during a remote request:
  - `lcl_done`=1 and `lcl_rdata`=`bi_rsp_data`.
  - The bus outputs are 0 from the next cycle on.
  - A reply in the first bus cycle is accepted.
- R6: For a bus request (`bi_valid`=1) whose segment equals NODE_ID while no reply is being driven:
  - The bank is accessed in that cycle with the low m bits.
  - In the next cycle, `bo_rsp_valid` pulses for one cycle with the bank word for a read, or 0 for a write.
  - The bank port is never claimed by both sides in one cycle.
- R7: A bus request to another segment causes no bank access and no reply.
- R8: When `bo_valid` is 0, `bo_addr`, `bo_wdata` and `bo_write` are 0. When `bo_rsp_valid` is 0, `bo_rsp_data` is 0.
- R9: `lcl_done` is high for exactly one cycle per request, and at most one request is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local request; held until `lcl_done` |
| lcl_write | input | 1 | 1 = write, 0 = read |
| lcl_addr | input | 32 | Local request address |
| lcl_wdata | input | DATA_W | Local write data |
| lcl_done | output | 1 | One-cycle completion pulse |
| lcl_rdata | output | DATA_W | Read data, valid with `lcl_done` |
| bank_en | output | 1 | Bank access enable |
| bank_we | output | 1 | Bank write enable |
| bank_addr | output | OFS_W | Bank word offset |
| bank_wdata | output | DATA_W | Bank write data |
| bank_rdata | input | DATA_W | Bank read data, one cycle after a read |
| bo_valid | output | 1 | Outgoing bus request |
| bo_write | output | 1 | Outgoing request is a write |
| bo_addr | output | 32 | Outgoing full address |
| bo_wdata | output | DATA_W | Outgoing write data |
| bi_rsp_valid | input | 1 | Reply seen on the bus |
| bi_rsp_data | input | DATA_W | Reply data seen on the bus |
| bi_valid | input | 1 | Request seen on the bus |
| bi_write | input | 1 | Request seen on the bus is a write |
| bi_addr | input | 32 | Address seen on the bus |
| bi_wdata | input | DATA_W | Write data seen on the bus |
| bo_rsp_valid | output | 1 | Reply this node drives onto the bus |
| bo_rsp_data | output | DATA_W | Reply data this node drives |

## Verification
The hardest case to reach from the ports is a remote request meeting its reply. The request's own bus outputs loop back into the target side, and the reply may land in the very first bus cycle. The bench ORs the bridge's bus outputs with its own external drivers, exactly as a shared bus would. This lets it check that the looped-back request is ignored, and that the responder can answer with zero to three cycles of delay. Directed cases at offset 0 and the top offset, and at foreign segments 0 and all-ones, are mixed with seeded random operations. These also cover a bus request that nearly matches the own segment.

// File: rtl/seg_bridge_pkg.sv
package seg_bridge_pkg;

    typedef enum logic [1:0] {
        LIDLE   = 2'd0,
        LBANK   = 2'd1,
        LREMOTE = 2'd2
    } lcl_state_e;

    typedef enum logic {
        TIDLE  = 1'b0,
        TREPLY = 1'b1
    } tgt_state_e;

endpackage

// File: rtl/seg_bridge_lcl.sv
module seg_bridge_lcl
    import seg_bridge_pkg::*;
#(
    parameter int OFS_W   = 10,
    parameter int DATA_W  = 32,
    parameter int NODE_ID = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bk_en,
    output logic              bk_we,
    output logic [OFS_W-1:0]  bk_addr,
    output logic [DATA_W-1:0] bk_wdata,
    input  logic [DATA_W-1:0] bk_rdata,
    output logic              out_valid,
    output logic              out_write,
    output logic [31:0]       out_addr,
    output logic [DATA_W-1:0] out_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data
);
    localparam int SEG_W = 32 - OFS_W;
    localparam logic [SEG_W-1:0] OWN_SEG = SEG_W'(NODE_ID);

    lcl_state_e state_q, state_d;
    logic       own_hit;

    assign own_hit = (req_addr[31:OFS_W] == OWN_SEG);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LIDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LIDLE:   if (req_valid) state_d = own_hit ? LBANK : LREMOTE;
            LBANK:   state_d = LIDLE;
            LREMOTE: if (rsp_valid) state_d = LIDLE;
            default: state_d = LIDLE;
        endcase
    end

    always_comb begin
        done      = 1'b0;
        rdata     = '0;
        bk_en     = 1'b0;
        bk_we     = 1'b0;
        bk_addr   = '0;
        bk_wdata  = '0;
        out_valid = 1'b0;
        out_write = 1'b0;
        out_addr  = '0;
        out_wdata = '0;
        unique case (state_q)
            LIDLE: begin
                if (req_valid && own_hit) begin
                    bk_en    = 1'b1;
                    bk_we    = req_write;
                    bk_addr  = req_addr[OFS_W-1:0];
                    bk_wdata = req_wdata;
                end
            end
            LBANK: begin
                done  = 1'b1;
                rdata = bk_rdata;
            end
            LREMOTE: begin
                out_valid = 1'b1;
                out_write = req_write;
                out_addr  = req_addr;
                out_wdata = req_wdata;
                if (rsp_valid) begin
                    done  = 1'b1;
                    rdata = rsp_data;
                end
            end
            default: ;
        endcase
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    remote_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !rsp_valid) |=> (out_valid && $stable(out_addr)));

    // R5
    remote_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rsp_valid) |-> done);

    // R5
    remote_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rsp_valid) |=> !out_valid);

endmodule

// File: rtl/seg_bridge_tgt.sv
module seg_bridge_tgt
    import seg_bridge_pkg::*;
#(
    parameter int OFS_W   = 10,
    parameter int DATA_W  = 32,
    parameter int NODE_ID = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_write,
    input  logic [31:0]       in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              bk_en,
    output logic              bk_we,
    output logic [OFS_W-1:0]  bk_addr,
    output logic [DATA_W-1:0] bk_wdata,
    input  logic [DATA_W-1:0] bk_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int SEG_W = 32 - OFS_W;
    localparam logic [SEG_W-1:0] OWN_SEG = SEG_W'(NODE_ID);

    tgt_state_e state_q, state_d;
    logic       hit;
    logic       wr_q;

    assign hit = in_valid && (in_addr[31:OFS_W] == OWN_SEG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TIDLE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == TIDLE && hit) wr_q <= in_write;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TIDLE:   if (hit) state_d = TREPLY;
            TREPLY:  state_d = TIDLE;
            default: state_d = TIDLE;
        endcase
    end

    always_comb begin
        bk_en     = 1'b0;
        bk_we     = 1'b0;
        bk_addr   = '0;
        bk_wdata  = '0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        unique case (state_q)
            TIDLE: begin
                if (hit) begin
                    bk_en    = 1'b1;
                    bk_we    = in_write;
                    bk_addr  = in_addr[OFS_W-1:0];
                    bk_wdata = in_wdata;
                end
            end
            TREPLY: begin
                rsp_valid = 1'b1;
                rsp_data  = wr_q ? '0 : bk_rdata;
            end
            default: ;
        endcase
    end

    // R6
    tgt_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_en && !rsp_valid) |=> rsp_valid);

    // R6
    tgt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/seg_bridge_bank_mux.sv
module seg_bridge_bank_mux #(
    parameter int OFS_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_we,
    input  logic [OFS_W-1:0]  l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              t_en,
    input  logic              t_we,
    input  logic [OFS_W-1:0]  t_addr,
    input  logic [DATA_W-1:0] t_wdata,
    output logic              m_en,
    output logic              m_we,
    output logic [OFS_W-1:0]  m_addr,
    output logic [DATA_W-1:0] m_wdata
);
    always_comb begin
        m_en    = l_en | t_en;
        m_we    = t_en ? t_we    : l_we;
        m_addr  = t_en ? t_addr  : l_addr;
        m_wdata = t_en ? t_wdata : l_wdata;
    end

    // R6
    bank_one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_en && t_en));

endmodule

// File: rtl/seg_mem_bridge.sv
module seg_mem_bridge #(
    parameter int OFS_W   = 10,
    parameter int DATA_W  = 32,
    parameter int NODE_ID = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcl_valid,
    input  logic              lcl_write,
    input  logic [31:0]       lcl_addr,
    input  logic [DATA_W-1:0] lcl_wdata,
    output logic              lcl_done,
    output logic [DATA_W-1:0] lcl_rdata,
    output logic              bank_en,
    output logic              bank_we,
    output logic [OFS_W-1:0]  bank_addr,
    output logic [DATA_W-1:0] bank_wdata,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic              bo_valid,
    output logic              bo_write,
    output logic [31:0]       bo_addr,
    output logic [DATA_W-1:0] bo_wdata,
    input  logic              bi_rsp_valid,
    input  logic [DATA_W-1:0] bi_rsp_data,
    input  logic              bi_valid,
    input  logic              bi_write,
    input  logic [31:0]       bi_addr,
    input  logic [DATA_W-1:0] bi_wdata,
    output logic              bo_rsp_valid,
    output logic [DATA_W-1:0] bo_rsp_data
);
    logic              l_en, l_we, t_en, t_we;
    logic [OFS_W-1:0]  l_addr, t_addr;
    logic [DATA_W-1:0] l_wdata, t_wdata;

    seg_bridge_lcl #(.OFS_W(OFS_W), .DATA_W(DATA_W), .NODE_ID(NODE_ID)) u_lcl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(lcl_valid), .req_write(lcl_write),
        .req_addr(lcl_addr), .req_wdata(lcl_wdata),
        .done(lcl_done), .rdata(lcl_rdata),
        .bk_en(l_en), .bk_we(l_we), .bk_addr(l_addr), .bk_wdata(l_wdata),
        .bk_rdata(bank_rdata),
        .out_valid(bo_valid), .out_write(bo_write),
        .out_addr(bo_addr), .out_wdata(bo_wdata),
        .rsp_valid(bi_rsp_valid), .rsp_data(bi_rsp_data)
    );

    seg_bridge_tgt #(.OFS_W(OFS_W), .DATA_W(DATA_W), .NODE_ID(NODE_ID)) u_tgt (
        .clk(clk), .rst_n(rst_n),
        .in_valid(bi_valid), .in_write(bi_write),
        .in_addr(bi_addr), .in_wdata(bi_wdata),
        .bk_en(t_en), .bk_we(t_we), .bk_addr(t_addr), .bk_wdata(t_wdata),
        .bk_rdata(bank_rdata),
        .rsp_valid(bo_rsp_valid), .rsp_data(bo_rsp_data)
    );

    seg_bridge_bank_mux #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_mux (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .t_en(t_en), .t_we(t_we), .t_addr(t_addr), .t_wdata(t_wdata),
        .m_en(bank_en), .m_we(bank_we), .m_addr(bank_addr), .m_wdata(bank_wdata)
    );

    // R8
    bus_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bo_valid |-> (bo_addr == '0 && bo_wdata == '0 && !bo_write));

    // R8
    bus_rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bo_rsp_valid |-> (bo_rsp_data == '0));

    // R3
    own_write_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_valid && lcl_write && bank_en && bank_we && !bo_rsp_valid && !bi_valid) |-> !bo_valid);

endmodule

// File: tb/seg_mem_bridge_tb.sv
`timescale 1ns/1ps
module seg_mem_bridge_tb;
    localparam int OFS_W   = 10;
    localparam int DATA_W  = 32;
    localparam int NODE_ID = 3;
    localparam int SEG_W   = 32 - OFS_W;
    localparam int DEPTH   = 1 << OFS_W;
    localparam logic [SEG_W-1:0] OWN = SEG_W'(NODE_ID);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              lcl_valid = 0, lcl_write = 0;
    logic [31:0]       lcl_addr = 0;
    logic [DATA_W-1:0] lcl_wdata = 0;
    logic              lcl_done;
    logic [DATA_W-1:0] lcl_rdata;
    logic              bank_en, bank_we;
    logic [OFS_W-1:0]  bank_addr;
    logic [DATA_W-1:0] bank_wdata, bank_rdata;
    logic              bo_valid, bo_write, bo_rsp_valid;
    logic [31:0]       bo_addr;
    logic [DATA_W-1:0] bo_wdata, bo_rsp_data;
    logic              ext_valid = 0, ext_write = 0, ext_rsp_valid = 0;
    logic [31:0]       ext_addr = 0;
    logic [DATA_W-1:0] ext_wdata = 0, ext_rsp_data = 0;
    logic              bi_valid, bi_write, bi_rsp_valid;
    logic [31:0]       bi_addr;
    logic [DATA_W-1:0] bi_wdata, bi_rsp_data;

    // shared bus modelled as OR of all drivers
    assign bi_valid     = ext_valid | bo_valid;
    assign bi_write     = ext_write | bo_write;
    assign bi_addr      = ext_addr | bo_addr;
    assign bi_wdata     = ext_wdata | bo_wdata;
    assign bi_rsp_valid = ext_rsp_valid | bo_rsp_valid;
    assign bi_rsp_data  = ext_rsp_data | bo_rsp_data;

    seg_mem_bridge #(.OFS_W(OFS_W), .DATA_W(DATA_W), .NODE_ID(NODE_ID)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lcl_valid(lcl_valid), .lcl_write(lcl_write), .lcl_addr(lcl_addr),
        .lcl_wdata(lcl_wdata), .lcl_done(lcl_done), .lcl_rdata(lcl_rdata),
        .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
        .bo_valid(bo_valid), .bo_write(bo_write), .bo_addr(bo_addr), .bo_wdata(bo_wdata),
        .bi_rsp_valid(bi_rsp_valid), .bi_rsp_data(bi_rsp_data),
        .bi_valid(bi_valid), .bi_write(bi_write), .bi_addr(bi_addr), .bi_wdata(bi_wdata),
        .bo_rsp_valid(bo_rsp_valid), .bo_rsp_data(bo_rsp_data)
    );

    // synchronous single-port bank model
    logic [DATA_W-1:0] ram [DEPTH];
    logic [DATA_W-1:0] shadow [DEPTH];
    logic [DATA_W-1:0] ram_q = '0;
    assign bank_rdata = ram_q;
    always_ff @(posedge clk) begin
        if (bank_en) begin
            if (bank_we) ram[bank_addr] <= bank_wdata;
            else         ram_q <= ram[bank_addr];
        end
    end

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    function automatic logic [DATA_W-1:0] init_word(input int i);
        return DATA_W'(i * 32'h0101_0007 + 32'h1);
    endfunction

    function automatic logic [DATA_W-1:0] remote_word(input logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [SEG_W-1:0] foreign_seg(input logic [SEG_W-1:0] s);
        return (s == OWN) ? (s ^ SEG_W'(1)) : s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // each task starts and ends at a negedge
    task automatic lcl_own(input bit wr, input logic [OFS_W-1:0] off, input logic [DATA_W-1:0] wd);
        lcl_valid = 1; lcl_write = wr; lcl_addr = {OWN, off}; lcl_wdata = wd;
        #1;
        chk(wr ? "R3 bank_en" : "R2 bank_en", 32'(bank_en), 32'd1);
        chk(wr ? "R3 bank_we" : "R2 bank_we", 32'(bank_we), 32'(wr));
        chk(wr ? "R3 bank_addr" : "R2 bank_addr", 32'(bank_addr), 32'(off));
        if (wr) chk("R3 bank_wdata", bank_wdata, wd);
        @(negedge clk); #1;
        chk(wr ? "R3 done" : "R2 done", 32'(lcl_done), 32'd1);
        chk("R3 no bus", 32'(bo_valid), 32'd0);
        if (wr) shadow[off] = wd;
        else    chk("R2 rdata", lcl_rdata, shadow[off]);
        @(negedge clk);
        lcl_valid = 0; lcl_write = 0; lcl_addr = 0; lcl_wdata = 0;
        #1;
        chk("R9 done single", 32'(lcl_done), 32'd0);
        @(negedge clk);
    endtask

    task automatic lcl_remote(input bit wr, input logic [31:0] a, input logic [DATA_W-1:0] wd, input int lat);
        lcl_valid = 1; lcl_write = wr; lcl_addr = a; lcl_wdata = wd;
        #1;
        chk("R4 no bank", 32'(bank_en), 32'd0);
        @(negedge clk); #1;
        chk("R4 bo_valid", 32'(bo_valid), 32'd1);
        chk("R4 bo_addr", bo_addr, a);
        chk("R4 bo_write", 32'(bo_write), 32'(wr));
        chk("R4 bo_wdata", bo_wdata, wd);
        chk("R9 no early done", 32'(lcl_done), 32'd0);
        for (int k = 0; k < lat; k++) begin
            @(negedge clk); #1;
            chk("R4 held valid", 32'(bo_valid), 32'd1);
            chk("R4 held addr", bo_addr, a);
        end
        ext_rsp_valid = 1; ext_rsp_data = wr ? '0 : remote_word(a);
        #1;
        chk("R5 done", 32'(lcl_done), 32'd1);
        if (!wr) chk("R5 rdata", lcl_rdata, remote_word(a));
        @(negedge clk);
        ext_rsp_valid = 0; ext_rsp_data = 0;
        lcl_valid = 0; lcl_write = 0; lcl_addr = 0; lcl_wdata = 0;
        #1;
        chk("R5 bus released", 32'(bo_valid), 32'd0);
        chk("R8 bo_addr zero", bo_addr, 32'd0);
        chk("R9 done single", 32'(lcl_done), 32'd0);
        @(negedge clk);
    endtask

    task automatic bus_hit(input bit wr, input logic [OFS_W-1:0] off, input logic [DATA_W-1:0] wd);
        ext_valid = 1; ext_write = wr; ext_addr = {OWN, off}; ext_wdata = wd;
        #1;
        chk("R6 bank_en", 32'(bank_en), 32'd1);
        chk("R6 bank_addr", 32'(bank_addr), 32'(off));
        chk("R6 bank_we", 32'(bank_we), 32'(wr));
        @(negedge clk); #1;
        chk("R6 reply valid", 32'(bo_rsp_valid), 32'd1);
        chk("R6 reply data", bo_rsp_data, wr ? '0 : shadow[off]);
        if (wr) shadow[off] = wd;
        ext_valid = 0; ext_write = 0; ext_addr = 0; ext_wdata = 0;
        @(negedge clk); #1;
        chk("R6 reply pulse", 32'(bo_rsp_valid), 32'd0);
        chk("R8 reply data zero", bo_rsp_data, 32'd0);
        @(negedge clk);
    endtask

    task automatic bus_miss(input logic [31:0] a);
        ext_valid = 1; ext_write = 0; ext_addr = a; ext_wdata = 0;
        #1;
        chk("R7 no bank", 32'(bank_en), 32'd0);
        @(negedge clk); #1;
        chk("R7 no reply", 32'(bo_rsp_valid), 32'd0);
        ext_valid = 0; ext_addr = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int unsigned seed_val;
        for (int i = 0; i < DEPTH; i++) begin
            ram[i] = init_word(i);
            shadow[i] = init_word(i);
        end
        seed_val = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        #1;
        chk("R1 done", 32'(lcl_done), 32'd0);
        chk("R1 bank_en", 32'(bank_en), 32'd0);
        chk("R1 bo_valid", 32'(bo_valid), 32'd0);
        chk("R1 bo_rsp_valid", 32'(bo_rsp_valid), 32'd0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // directed corners
        lcl_own(0, '0, '0);
        lcl_own(1, '1, 32'hDEAD_BEEF);
        lcl_own(0, '1, '0);
        lcl_remote(0, {SEG_W'(0), OFS_W'(5)}, '0, 0);
        lcl_remote(1, {{SEG_W{1'b1}}, {OFS_W{1'b1}}}, 32'h1234_5678, 3);
        bus_hit(0, '1, '0);
        bus_hit(1, '0, 32'hCAFE_0001);
        bus_hit(0, '0, '0);
        bus_miss({OWN ^ SEG_W'(1), OFS_W'(7)});
        bus_miss({OWN ^ {1'b1, {(SEG_W-1){1'b0}}}, OFS_W'(0)});

        // seeded random mix
        for (int n = 0; n < 300; n++) begin
            int unsigned op;
            logic [OFS_W-1:0] off;
            logic [DATA_W-1:0] wd;
            logic [SEG_W-1:0] fs;
            op  = $urandom % 4;
            off = OFS_W'($urandom);
            wd  = DATA_W'($urandom);
            fs  = foreign_seg(SEG_W'($urandom));
            case (op)
                0: lcl_own(1'($urandom), off, wd);
                1: lcl_remote(1'($urandom), {fs, off}, wd, int'($urandom % 4));
                2: bus_hit(1'($urandom), off, wd);
                default: bus_miss({fs, off});
            endcase
        end
        if (seed_val == 32'hFFFF_FFFF) $display("seed edge");
        summary();
    end
endmodule